// File: doc/BRIEF.md
# Direct-Mapped Write-Back Block Cache

This block sits between a processor's word-wide load/store port and a memory that moves whole 128-bit blocks. It holds sixteen lines. Each line has one four-word block, a 24-bit tag, a valid flag and a dirty flag. A single tag comparator decides hit or miss for the line that the request's index bits select. Hits are answered in the same cycle as the request. Stores that hit change only the cached copy and mark the line dirty.

On a miss the processor is stalled. If the line being replaced is valid and dirty, its whole block is first written back to the address rebuilt from its stored tag and its index. The missing block is then fetched. A store miss allocates the line, merges the store word into the fetched block and leaves the line dirty. A flush input drops every line's contents at once. Dirty data is discarded by a flush and is not written out.

The processor raises `cpu_req_i` and holds the request (write flag, address, data) steady until it sees `cpu_ack_o` high in a cycle. In that acknowledge cycle `cpu_rdata_o` carries the addressed word, and the request completes at the following clock edge. On the memory side, `mem_valid_o` with `mem_we_o` is held until `mem_ready_i`. A read block is taken from `mem_rdata_i` in the cycle where `mem_valid_o`, `mem_ready_i` and a low `mem_we_o` coincide.

Top module: `dm_wb_cache`

## Requirements
- R1: The byte address is split as word select = bits [3:2], line index = bits [7:4] and tag = bits [31:8]. Lines with different indices hold blocks independently, while two tags that share an index replace each other.
- R2: A request hits when the indexed line is valid and its tag equals the address tag. A hit raises `cpu_ack_o` in the same cycle as the request, with the addressed word on `cpu_rdata_o`, and makes no memory request.
- R3: A write hit replaces only the addressed word in the line, sets the line's dirty flag and makes no memory request.
- R4: A miss whose victim line is valid and dirty first issues one memory write. Its address is {victim tag, index, 4'h0} and its data is the victim block. The fill read for the new block follows it directly.
- R5: A miss whose victim is invalid or clean issues no memory write and exactly one memory read, at the block-aligned address {tag, index, 4'h0}.
- R6: After a read-miss fill the line is valid and clean. Later reads to that block hit, and replacing it causes no write-back.
- R7: A write miss allocates the line, stores the new word over the fetched block and leaves the line dirty, so that a later eviction writes the merged block back.
- R8: While a memory request is outstanding, `cpu_ack_o` stays low. The acknowledge comes in the cycle right after the fill handshake.
- R9: Once raised, `mem_valid_o`, `mem_addr_o` and `mem_we_o` are held unchanged until `mem_ready_i` is seen.
- R10: After reset no line is valid, so the first access to any block misses with no write-back.
- R11: A one-cycle `flush_i` in an idle cycle with no request invalidates all lines and discards their dirty data. The next access misses, makes no write-back, and returns the memory's old contents.
- R12: Word w of a block sits at bits [32w+31:32w] of the 128-bit memory data, in both the fill and the write-back direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all lines (taken when idle) |
| cpu_req_i | input | 1 | Processor request present |
| cpu_we_i | input | 1 | Request is a store |
| cpu_addr_i | input | 32 | Byte address of the request |
| cpu_wdata_i | input | 32 | Store data |
| cpu_ack_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | 32 | Load data, valid with the acknowledge |
| mem_valid_o | output | 1 | Memory block request |
| mem_we_o | output | 1 | Memory request is a block write |
| mem_addr_o | output | 32 | Block-aligned memory byte address |
| mem_wdata_o | output | 128 | Block being written back |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 128 | Fill block, valid with ready on a read |

## Verification
The hardest situation to reach is a write-back whose data has itself been shaped by earlier stores. To get there, a line must be filled, changed by a write hit or a write miss, and then evicted by a second tag on the same index. The written-back block must then be fetched again to show that the merge and the word order survived the trip. Directed sequences build exactly this chain on several indices, with memory ready delays of zero to three cycles. A long pseudo-random stream over a 16 KB window then forces many same-index collisions with mixed stores. A behavioural model of tags, flags and memory predicts every write-back address and block, every fill address, and every load word.

// File: rtl/cache_pkg.sv
// Shared types for the direct-mapped write-back cache.
package cache_pkg;
    // Controller phases: idle lookup, victim write-back, block fetch, late answer.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_FILL      = 2'd2,
        ST_RESPOND   = 2'd3
    } cache_state_t;
endpackage

// File: rtl/cache_addr_split.sv
// Splits a byte address into word select, line index and tag.
// Assumes the address width covers the byte, word and index fields.
module cache_addr_split #(
    parameter int ADDR_W = 32,
    parameter int BOFF_W = 2,
    parameter int WSEL_W = 2,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - IDX_W - WSEL_W - BOFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WSEL_W-1:0] word_sel,
    output logic [IDX_W-1:0]  index,
    output logic [TAG_W-1:0]  tag
);
    // Pure field extraction; the byte offset is unused by a word interface.
    always_comb begin
        word_sel = addr[BOFF_W +: WSEL_W];
        index    = addr[BOFF_W + WSEL_W +: IDX_W];
        tag      = addr[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/cache_store.sv
// Line storage: block data, tags and valid/dirty flags per line.
// One line is read combinationally through rd_idx. A fill writes a whole
// line; a word write changes one word and marks the line dirty.
// Assumes fill_en and word_wr_en never fire together.
module cache_store #(
    parameter int LINES   = 16,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 24,
    parameter int WORD_W  = 32,
    parameter int WSEL_W  = 2,
    parameter int BLOCK_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_all,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [BLOCK_W-1:0] rd_block,
    input  logic               word_wr_en,
    input  logic [WSEL_W-1:0]  word_sel,
    input  logic [WORD_W-1:0]  word_data,
    input  logic               fill_en,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [BLOCK_W-1:0] fill_block,
    input  logic               fill_dirty
);
    logic [LINES-1:0]   valid_q;
    logic [LINES-1:0]   dirty_q;
    logic [TAG_W-1:0]   tag_q   [LINES];
    logic [BLOCK_W-1:0] block_q [LINES];

    // Valid and dirty flags: cleared by reset or flush, set by fill/write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_all) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[rd_idx] <= 1'b1;
            dirty_q[rd_idx] <= fill_dirty;
        end else if (word_wr_en) begin
            dirty_q[rd_idx] <= 1'b1;
        end
    end

    // Tag and data arrays: no reset, qualified by the valid flags.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (fill_en && rd_idx == IDX_W'(i)) begin
                tag_q[i]   <= fill_tag;
                block_q[i] <= fill_block;
            end else if (word_wr_en && rd_idx == IDX_W'(i)) begin
                block_q[i][word_sel*WORD_W +: WORD_W] <= word_data;
            end
        end
    end

    // Read port for the indexed line.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_block = block_q[rd_idx];
    end
endmodule

// File: rtl/cache_ctrl.sv
// Miss sequencer. Answers hits in the idle cycle. On a miss it writes a
// dirty victim back, fetches the block, then acknowledges one cycle later.
// Assumes the processor holds its request steady until acknowledged.
module cache_ctrl
    import cache_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         cpu_req,
    input  logic         cpu_we,
    input  logic         hit,
    input  logic         victim_valid,
    input  logic         victim_dirty,
    input  logic         mem_ready,
    output cache_state_t state,
    output logic         cpu_ack,
    output logic         mem_valid,
    output logic         mem_we,
    output logic         hit_write,
    output logic         fill_en,
    output logic         flush_all
);
    cache_state_t state_q, state_d;

    // Next-phase and strobe decode.
    always_comb begin
        state_d   = state_q;
        cpu_ack   = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        hit_write = 1'b0;
        fill_en   = 1'b0;
        flush_all = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (flush) begin
                    flush_all = 1'b1;
                end else if (cpu_req) begin
                    if (hit) begin
                        cpu_ack   = 1'b1;
                        hit_write = cpu_we;
                    end else if (victim_valid && victim_dirty) begin
                        state_d = ST_WRITEBACK;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_WRITEBACK: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                if (mem_ready) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    fill_en = 1'b1;
                    state_d = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                cpu_ack = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/dm_wb_cache.sv
// Direct-mapped write-back cache with multi-word lines.
// One comparator checks the indexed line; misses move whole blocks.
// Assumes the processor holds request fields steady until cpu_ack_o.
module dm_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_i,
    input  logic                    cpu_req_i,
    input  logic                    cpu_we_i,
    input  logic [ADDR_W-1:0]       cpu_addr_i,
    input  logic [WORD_W-1:0]       cpu_wdata_i,
    output logic                    cpu_ack_o,
    output logic [WORD_W-1:0]       cpu_rdata_o,
    output logic                    mem_valid_o,
    output logic                    mem_we_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic [WORD_W*WORDS-1:0] mem_wdata_o,
    input  logic                    mem_ready_i,
    input  logic [WORD_W*WORDS-1:0] mem_rdata_i
);
    localparam int BOFF_W  = $clog2(WORD_W / 8);
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - IDX_W - WSEL_W - BOFF_W;
    localparam int BLOCK_W = WORD_W * WORDS;
    localparam int LOW_W   = WSEL_W + BOFF_W;

    logic [WSEL_W-1:0]  req_word;
    logic [IDX_W-1:0]   req_idx;
    logic [TAG_W-1:0]   req_tag;
    logic               line_valid, line_dirty, hit;
    logic [TAG_W-1:0]   line_tag;
    logic [BLOCK_W-1:0] line_block, fill_block;
    logic               hit_write, fill_en, flush_all;
    cache_state_t       state;

    cache_addr_split #(
        .ADDR_W(ADDR_W), .BOFF_W(BOFF_W), .WSEL_W(WSEL_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_split (
        .addr(cpu_addr_i), .word_sel(req_word), .index(req_idx), .tag(req_tag)
    );

    cache_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .WORD_W(WORD_W), .WSEL_W(WSEL_W), .BLOCK_W(BLOCK_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .rd_idx(req_idx),
        .rd_valid(line_valid), .rd_dirty(line_dirty), .rd_tag(line_tag),
        .rd_block(line_block), .word_wr_en(hit_write), .word_sel(req_word),
        .word_data(cpu_wdata_i), .fill_en(fill_en), .fill_tag(req_tag),
        .fill_block(fill_block), .fill_dirty(cpu_we_i)
    );

    // Single tag comparator for the whole cache.
    assign hit = line_valid && (line_tag == req_tag);

    cache_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush_i), .cpu_req(cpu_req_i),
        .cpu_we(cpu_we_i), .hit(hit), .victim_valid(line_valid),
        .victim_dirty(line_dirty), .mem_ready(mem_ready_i), .state(state),
        .cpu_ack(cpu_ack_o), .mem_valid(mem_valid_o), .mem_we(mem_we_o),
        .hit_write(hit_write), .fill_en(fill_en), .flush_all(flush_all)
    );

    // Fill merge: a store miss replaces its word in the fetched block.
    for (genvar w = 0; w < WORDS; w++) begin : g_merge
        always_comb begin
            if (cpu_we_i && req_word == WSEL_W'(w))
                fill_block[w*WORD_W +: WORD_W] = cpu_wdata_i;
            else
                fill_block[w*WORD_W +: WORD_W] = mem_rdata_i[w*WORD_W +: WORD_W];
        end
    end

    // Memory address: victim's rebuilt address during write-back, else the request block.
    always_comb begin
        if (state == ST_WRITEBACK) mem_addr_o = {line_tag, req_idx, {LOW_W{1'b0}}};
        else                       mem_addr_o = {req_tag,  req_idx, {LOW_W{1'b0}}};
    end

    assign mem_wdata_o = line_block;
    assign cpu_rdata_o = line_block[req_word*WORD_W +: WORD_W];
endmodule

// File: rtl/dm_wb_cache_checker.sv
// Protocol properties for dm_wb_cache, attached by bind.
module dm_wb_cache_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_i,
    input logic              cpu_ack_o,
    input logic              mem_valid_o,
    input logic              mem_we_o,
    input logic              mem_ready_i,
    input logic [ADDR_W-1:0] mem_addr_o
);
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack_o |-> cpu_req_i);                                                   // R8
    AST_NO_ACK_WHILE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> !cpu_ack_o);                                                // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R9
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_we_o && mem_ready_i |=> mem_valid_o && !mem_we_o);      // R4
    AST_FILL_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_we_o && mem_ready_i |=> cpu_ack_o);                     // R8
endmodule

bind dm_wb_cache dm_wb_cache_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req_i), .cpu_ack_o(cpu_ack_o),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o)
);

// File: tb/dm_wb_cache_bench.sv
// Bench: behavioural cache/memory model predicts every transaction.
module dm_wb_cache_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush_i = 1'b0;
    logic         cpu_req_i = 1'b0;
    logic         cpu_we_i = 1'b0;
    logic [31:0]  cpu_addr_i = '0;
    logic [31:0]  cpu_wdata_i = '0;
    logic         cpu_ack_o;
    logic [31:0]  cpu_rdata_o;
    logic         mem_valid_o, mem_we_o;
    logic [31:0]  mem_addr_o;
    logic [127:0] mem_wdata_o;
    logic         mem_ready_i = 1'b0;
    logic [127:0] mem_rdata_i;

    dm_wb_cache u_dm_wb_cache (.*);

    always #10 clk = ~clk;   // 50 MHz

    logic [127:0] bench_mem [1024];   // memory the design talks to
    logic [127:0] ref_mem   [1024];   // memory as the model expects it
    logic [23:0]  m_tag   [16];
    bit           m_valid [16];
    bit           m_dirty [16];
    logic [127:0] m_blk   [16];

    int n_checks = 0, n_fail = 0;
    int wb_seen = 0, fill_seen = 0;
    int rdy_lat = 0, wait_cnt = 0;
    bit hs_done = 1'b0;
    bit exp_wb_ok = 1'b0;
    logic [31:0]  exp_wb_addr, exp_fill_addr;
    logic [127:0] exp_wb_data;

    assign mem_rdata_i = bench_mem[mem_addr_o[13:4]];

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Memory ready generator: ready after rdy_lat waiting cycles.
    always @(negedge clk) begin
        if (hs_done || !mem_valid_o) begin
            wait_cnt = 0;
            hs_done  = 1'b0;
        end
        if (mem_valid_o) begin
            mem_ready_i = (wait_cnt >= rdy_lat);
            wait_cnt++;
        end else begin
            mem_ready_i = 1'b0;
        end
    end

    // Memory handshake monitor: checks write-back and fill addresses/data.
    always @(posedge clk) begin
        if (rst_n && mem_valid_o && mem_ready_i) begin
            hs_done = 1'b1;
            if (mem_we_o) begin
                wb_seen++;
                check("R4", "write-back expected", 128'(exp_wb_ok), 128'(1));
                check("R4", "write-back address", 128'(mem_addr_o), 128'(exp_wb_addr));
                check("R12", "write-back block", mem_wdata_o, exp_wb_data);
                bench_mem[mem_addr_o[13:4]] <= mem_wdata_o;
            end else begin
                fill_seen++;
                check("R5", "fill address", 128'(mem_addr_o), 128'(exp_fill_addr));
            end
        end
    end

    // Every cycle: no acknowledge while a memory request is open (R8).
    always @(negedge clk) begin
        if (rst_n && cpu_ack_o && mem_valid_o) begin
            n_fail++;
            $display("FAIL R8 ack during memory request: actual 1 expected 0");
        end
    end

    task automatic access(input bit we, input logic [31:0] addr,
                          input logic [31:0] wd, input string rq);
        int idx, w, cycles, wb0, f0;
        logic [23:0] tg;
        bit exp_hit, exp_wb;
        logic [31:0] exp_rd;
        idx = int'(addr[7:4]);
        w   = int'(addr[3:2]);
        tg  = addr[31:8];
        exp_hit = m_valid[idx] && m_tag[idx] == tg;
        exp_wb  = 1'b0;
        if (!exp_hit) begin
            if (m_valid[idx] && m_dirty[idx]) begin
                exp_wb      = 1'b1;
                exp_wb_addr = {m_tag[idx], addr[7:4], 4'h0};
                exp_wb_data = m_blk[idx];
                ref_mem[{m_tag[idx][5:0], addr[7:4]}] = m_blk[idx];
            end
            exp_fill_addr = {tg, addr[7:4], 4'h0};
            m_blk[idx]   = ref_mem[addr[13:4]];
            m_tag[idx]   = tg;
            m_valid[idx] = 1'b1;
            m_dirty[idx] = 1'b0;
        end
        if (we) begin
            m_blk[idx][w*32 +: 32] = wd;
            m_dirty[idx] = 1'b1;
        end
        exp_rd    = m_blk[idx][w*32 +: 32];
        exp_wb_ok = exp_wb;
        wb0 = wb_seen;
        f0  = fill_seen;
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = addr; cpu_wdata_i = wd;
        cycles = 0;
        while (1) begin
            #2;
            if (cpu_ack_o) break;
            @(negedge clk);
            cycles++;
            if (cycles > 100) break;
        end
        if (exp_hit) check("R2", "hit ack latency", 128'(cycles), 128'(0));
        else         check("R8", "miss stalls", 128'(cycles > 0), 128'(1));
        if (!we) check(rq, "load data", 128'(cpu_rdata_o), 128'(exp_rd));
        check(exp_wb ? "R4" : "R5", "write-backs", 128'(wb_seen - wb0), 128'(exp_wb));
        check(exp_hit ? "R2" : "R5", "fills", 128'(fill_seen - f0), 128'(!exp_hit));
        @(posedge clk);
        exp_wb_ok = 1'b0;
    endtask

    task automatic idle_flush();
        @(negedge clk);
        cpu_req_i = 1'b0; flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 1'b0;
            m_dirty[i] = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        int seed;
        for (int b = 0; b < 1024; b++) begin
            for (int w = 0; w < 4; w++) begin
                bench_mem[b][w*32 +: 32] = 32'hA500_0000 ^ 32'(b * 16 + w * 3 + 1);
                ref_mem[b][w*32 +: 32]   = 32'hA500_0000 ^ 32'(b * 16 + w * 3 + 1);
            end
        end
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_blk[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R10", "ack after reset", 128'(cpu_ack_o), 128'(0));
        check("R10", "mem idle after reset", 128'(mem_valid_o), 128'(0));
        rst_n = 1'b1;

        // Cold miss, word order, hits and write hit.
        access(1'b0, 32'h0000_0104, '0, "R10");
        access(1'b0, 32'h0000_0108, '0, "R12");
        access(1'b1, 32'h0000_010C, 32'hDEAD_BEEF, "R3");
        access(1'b0, 32'h0000_010C, '0, "R3");
        access(1'b0, 32'h0000_0100, '0, "R3");
        // Same index, new tag: dirty victim written back first.
        rdy_lat = 2;
        access(1'b0, 32'h0000_0204, '0, "R4");
        access(1'b0, 32'h0000_010C, '0, "R4");   // clean victim, merged word back
        access(1'b0, 32'h0000_0204, '0, "R6");
        // Write miss allocates and merges.
        rdy_lat = 3;
        access(1'b1, 32'h0000_03A8, 32'h1234_5678, "R7");
        access(1'b0, 32'h0000_03A4, '0, "R7");
        access(1'b0, 32'h0000_03A8, '0, "R7");
        access(1'b0, 32'h0000_04A0, '0, "R7");
        access(1'b0, 32'h0000_03A8, '0, "R7");
        // Independent indices coexist.
        rdy_lat = 0;
        access(1'b0, 32'h0000_0150, '0, "R1");
        access(1'b0, 32'h0000_0160, '0, "R1");
        access(1'b0, 32'h0000_0154, '0, "R1");
        access(1'b0, 32'h0000_0168, '0, "R1");
        // Flush discards dirty data.
        access(1'b1, 32'h0000_0170, 32'hCAFE_F00D, "R11");
        idle_flush();
        access(1'b0, 32'h0000_0170, '0, "R11");
        access(1'b0, 32'h0000_0150, '0, "R11");
        // Pseudo-random stream with collisions.
        seed = 32'h1357;
        for (int k = 0; k < 400; k++) begin
            seed = seed * 1103515245 + 12345;
            rdy_lat = (seed >>> 20) & 3;
            access(((seed >>> 9) & 3) == 0, {18'h0, seed[17:6], 2'b00},
                   32'(seed ^ k), "R1");
        end
        @(negedge clk);
        cpu_req_i = 1'b0;
        repeat (2) @(negedge clk);
        report();
    end
endmodule